// File: doc/BRIEF.md
# Masked-CRC Wake Pattern Detector

The detector sits on the receive byte stream of an Ethernet port and decides, for every incoming frame, which of its programmed wake patterns the frame carries. Each pattern slot holds a byte-select mask over the opening 64 bytes of the frame and the CRC-32 value that the selected bytes must produce. The selected bytes are folded into a per-slot CRC one byte per clock. The result is compared once per frame: on the 64th byte, or on the last byte of a shorter frame.

A small 16-bit register port loads each slot's mask and expected CRC. A slot hit shows as a single-cycle pulse on its own output. The OR of all slot pulses drives a single wake line for the power controller.

Top module: `wake_detect`

## Requirements
- R1: After reset every mask and CRC register reads 0x0000 and `slot_match` and `wake` are low.
- R2: Register address = slot*8 + index. Index 0..3 are mask words 0..3, index 4 is CRC bits 15:0, and index 5 is CRC bits 31:16. All six are read/write through `cfg_we`/`cfg_wdata`, and reads appear combinationally on `cfg_rdata`. Index 6 and 7 ignore writes and read 0x0000.
- R3: Bit b of mask word w selects frame byte 16*w+b+1, where the byte carrying `in_sof` is byte 1.
- R4: The slot CRC is the reflected CRC-32 (polynomial 0x04C11DB7), seeded with 0xFFFFFFFF and inverted at the end, taken over the selected bytes only. The nine bytes "123456789" selected give 0xCBF43926.
- R5: In a frame of 64 bytes or more, the comparison happens on byte 64. A hit pulses `slot_match` in the cycle after byte 64 is accepted. Bytes after byte 64 have no effect.
- R6: When `in_eof` comes on byte L < 64, the comparison uses the CRC of the selected bytes among bytes 1..L. A hit pulses in the cycle after byte L.
- R7: A slot whose 64 mask bits are all zero never matches, even when its expected CRC equals the CRC of an empty selection (0x00000000).
- R8: Slots are evaluated independently, and `wake` is high exactly when any `slot_match` bit is high.
- R9: A byte with `in_sof` always starts a new frame, abandoning any partial one. Valid bytes arriving with no open frame are ignored.
- R10: Each frame produces at most one `slot_match` pulse per slot, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (4) | Register address, slot*8 + index |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |
| slot_match | output | NUM_SLOTS (2) | Per-slot match pulse |
| wake | output | 1 | OR of all slot matches |

## Verification
A sweep walks a single selected byte through all 64 window positions. It runs over 70-byte frames, with one slot holding the correct CRC and the other holding a CRC off by one bit. This separates correct mask bit mapping and window timing from off-by-one position errors and from matches after byte 64. A second sweep covers frame lengths 1 to 20 with a full mask. The rival slot expects one extra byte, which shows whether the early-end comparison uses exactly the bytes received. Fixed cases apply the known CRC check value, all-zero masks directly after reset, a frame restarted mid-way, and stray bytes outside a frame.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

    // One byte of the reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc32_byte(logic [31:0] cur, logic [7:0] b);
        logic [31:0] r;
        r = cur ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/wake_cfg_regs.sv
module wake_cfg_regs #(
    parameter int NUM_SLOTS = 2,
    parameter int WIN_BYTES = 64,
    parameter int SLOT_W    = 1,
    parameter int ADDR_W    = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 we,
    input  logic [ADDR_W-1:0]                    addr,
    input  logic [15:0]                          wdata,
    output logic [15:0]                          rdata,
    output logic [NUM_SLOTS-1:0][WIN_BYTES-1:0]  mask_o,
    output logic [NUM_SLOTS-1:0][31:0]           crc_o
);
    localparam int WORDS = WIN_BYTES / 16;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][WIN_BYTES-1:0] mask;
        logic [NUM_SLOTS-1:0][31:0]          crc;
    } regs_t;

    regs_t q, d;
    logic [SLOT_W-1:0] slot;
    logic [2:0]        idx;

    always_comb begin
        d     = q;
        rdata = 16'h0;
        slot  = addr[ADDR_W-1:3];
        idx   = addr[2:0];
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (SLOT_W'(s) == slot) begin
                for (int w = 0; w < WORDS; w++) begin
                    if (3'(w) == idx) begin
                        rdata = q.mask[s][w*16 +: 16];
                        if (we) d.mask[s][w*16 +: 16] = wdata;
                    end
                end
                if (idx == 3'(WORDS)) begin
                    rdata = q.crc[s][15:0];
                    if (we) d.crc[s][15:0] = wdata;
                end
                if (idx == 3'(WORDS + 1)) begin
                    rdata = q.crc[s][31:16];
                    if (we) d.crc[s][31:16] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mask_o = q.mask;
    assign crc_o  = q.crc;
endmodule

// File: rtl/wake_frame_track.sv
module wake_frame_track #(
    parameter int WIN_BYTES = 64,
    parameter int POS_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic             byte_ok,
    output logic             byte_first,
    output logic [POS_W-1:0] byte_pos,
    output logic             in_win,
    output logic             eval
);
    typedef struct packed {
        logic             active;
        logic [POS_W-1:0] pos;
    } trk_t;

    trk_t q, d;

    always_comb begin
        d          = q;
        byte_ok    = in_valid && (in_sof || q.active);
        byte_first = in_sof;
        byte_pos   = in_sof ? '0 : q.pos;
        in_win     = byte_pos < POS_W'(WIN_BYTES);
        eval       = byte_ok && in_win &&
                     (in_eof || byte_pos == POS_W'(WIN_BYTES - 1));
        if (byte_ok) begin
            d.active = !in_eof;
            d.pos    = in_win ? byte_pos + 1'b1 : q.pos;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/wake_slot.sv
module wake_slot
    import wake_pkg::*;
#(
    parameter int WIN_BYTES = 64,
    parameter int IDX_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 byte_ok,
    input  logic                 byte_first,
    input  logic                 in_win,
    input  logic                 eval,
    input  logic [IDX_W-1:0]     byte_idx,
    input  logic [7:0]           byte_data,
    input  logic [WIN_BYTES-1:0] sel_mask,
    input  logic [31:0]          want_crc,
    output logic                 hit
);
    typedef struct packed {
        logic [31:0] crc;
        logic        hit;
    } slot_t;

    slot_t       q, d;
    logic [31:0] base, nxt;
    logic        take;

    always_comb begin
        d     = q;
        d.hit = 1'b0;
        base  = byte_first ? CRC_SEED : q.crc;
        take  = in_win && sel_mask[byte_idx];
        nxt   = take ? crc32_byte(base, byte_data) : base;
        if (byte_ok) begin
            d.crc = nxt;
            if (eval) d.hit = (|sel_mask) && ((~nxt) == want_crc);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hit = q.hit;
endmodule

// File: rtl/wake_detect.sv
module wake_detect #(
    parameter int NUM_SLOTS = 2,
    parameter int WIN_BYTES = 64,
    parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    parameter int ADDR_W    = SLOT_W + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    input  logic                 in_sof,
    input  logic                 in_eof,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [15:0]          cfg_wdata,
    output logic [15:0]          cfg_rdata,
    output logic [NUM_SLOTS-1:0] slot_match,
    output logic                 wake
);
    localparam int POS_W = $clog2(WIN_BYTES + 1);
    localparam int IDX_W = $clog2(WIN_BYTES);

    logic [NUM_SLOTS-1:0][WIN_BYTES-1:0] mask_w;
    logic [NUM_SLOTS-1:0][31:0]          crc_w;
    logic             byte_ok, byte_first, in_win, eval;
    logic [POS_W-1:0] byte_pos;

    wake_cfg_regs #(
        .NUM_SLOTS(NUM_SLOTS), .WIN_BYTES(WIN_BYTES),
        .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .mask_o(mask_w), .crc_o(crc_w)
    );

    wake_frame_track #(.WIN_BYTES(WIN_BYTES), .POS_W(POS_W)) u_track (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .byte_ok(byte_ok), .byte_first(byte_first),
        .byte_pos(byte_pos), .in_win(in_win), .eval(eval)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        wake_slot #(.WIN_BYTES(WIN_BYTES), .IDX_W(IDX_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .byte_ok(byte_ok),
            .byte_first(byte_first), .in_win(in_win), .eval(eval),
            .byte_idx(byte_pos[IDX_W-1:0]), .byte_data(in_data),
            .sel_mask(mask_w[s]), .want_crc(crc_w[s]), .hit(slot_match[s])
        );
    end

    assign wake = |slot_match;
endmodule

module wake_detect_chk #(
    parameter int NUM_SLOTS = 2,
    parameter int WIN_BYTES = 64,
    parameter int POS_W     = 7
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                byte_ok,
    input logic                                eval,
    input logic [POS_W-1:0]                    byte_pos,
    input logic [NUM_SLOTS-1:0][WIN_BYTES-1:0] mask,
    input logic [NUM_SLOTS-1:0]                slot_match
);
    // R5: position counter never runs past the window
    a_r5_pos_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        byte_pos <= POS_W'(WIN_BYTES));

    // R10: a match only follows a comparison cycle
    a_r10_match_after_eval: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_match) |-> $past(eval));

    // R9: an ignored (stray or idle) cycle produces no match next cycle
    a_r9_ignored_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_ok |=> !(|slot_match));

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
        // R7: an empty mask never yields a match
        a_r7_empty_mask_silent: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(mask[s]) == '0) |-> !slot_match[s]);
    end
endmodule

bind wake_detect wake_detect_chk #(
    .NUM_SLOTS(NUM_SLOTS), .WIN_BYTES(WIN_BYTES), .POS_W(POS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .byte_ok(byte_ok), .eval(eval),
    .byte_pos(byte_pos), .mask(mask_w), .slot_match(slot_match)
);

// File: tb/wake_detect_test.sv
`timescale 1ns/1ps
module wake_detect_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = 8'h0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = 4'h0;
    logic [15:0] cfg_wdata = 16'h0;
    logic [15:0] cfg_rdata;
    logic [1:0]  slot_match;
    logic        wake;

    int total = 0, bad = 0;
    int hit_cnt0, hit_cnt1, hit_at0, wake_cnt, nb;
    logic [7:0] fr [0:127];
    bit finished = 0;

    always #5 clk = ~clk;

    wake_detect uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .slot_match(slot_match), .wake(wake)
    );

    function automatic logic [31:0] ref_crc(logic [63:0] m, int len);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < len && i < 64; i++) begin
            if (m[i]) begin
                c = c ^ {24'h0, fr[i]};
                for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
            end
        end
        return ~c;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sample();
        if (slot_match[0]) begin hit_cnt0++; hit_at0 = nb; end
        if (slot_match[1]) hit_cnt1++;
        if (wake) wake_cnt++;
    endtask

    task automatic clear_hits();
        hit_cnt0 = 0; hit_cnt1 = 0; hit_at0 = -1; wake_cnt = 0; nb = 0;
    endtask

    task automatic push(logic [7:0] b, logic s, logic e);
        @(negedge clk);
        sample();
        in_valid = 1'b1; in_data = b; in_sof = s; in_eof = e;
        nb++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sample();
            in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        end
    endtask

    task automatic send_frame(int len);
        for (int i = 0; i < len; i++) push(fr[i], i == 0, i == len - 1);
        idle(3);
    endtask

    task automatic wr(int a, logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(int a, output logic [15:0] v);
        @(negedge clk);
        cfg_addr = 4'(a);
        #1 v = cfg_rdata;
    endtask

    task automatic prog(int s, logic [63:0] m, logic [31:0] c);
        for (int w = 0; w < 4; w++) wr(s*8 + w, m[w*16 +: 16]);
        wr(s*8 + 4, c[15:0]);
        wr(s*8 + 5, c[31:16]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [31:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of registers and outputs
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            chk("R1 reg reset", v, 0);
        end
        chk("R1 outputs after reset", {wake, slot_match}, 0);

        // R7: all-zero masks with CRC 0 (the empty-selection CRC) never match
        for (int i = 0; i < 10; i++) fr[i] = 8'(i * 3 + 1);
        clear_hits(); send_frame(10);
        chk("R7 empty mask slot0", hit_cnt0, 0);
        chk("R7 empty mask slot1", hit_cnt1, 0);

        // R2: register map read/write, index 6 and 7 reserved
        for (int a = 0; a < 16; a++) wr(a, 16'(16'hA500 + a * 16'h0111));
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            chk("R2 reg readback", v, ((a % 8) >= 6) ? 0 : (16'hA500 + a * 16'h0111) & 16'hFFFF);
        end

        // R4: known check value over "123456789"
        for (int i = 0; i < 9; i++) fr[i] = 8'(8'h31 + i);
        prog(0, 64'h1FF, 32'hCBF43926);
        prog(1, 64'h0, 32'h0);
        clear_hits(); send_frame(9);
        chk("R4 check value match", hit_cnt0, 1);
        chk("R7 empty slot stays silent", hit_cnt1, 0);

        // R3 R5 R8 R10: single selected byte swept across the window
        for (int k = 0; k < 64; k++) begin
            for (int i = 0; i < 70; i++) fr[i] = 8'(i * 37 + k * 11 + 5);
            c = ref_crc(64'h1 << k, 70);
            prog(0, 64'h1 << k, c);
            prog(1, 64'h1 << k, c ^ 32'h1);
            clear_hits(); send_frame(70);
            chk("R3 R5 single pulse slot0", hit_cnt0, 1);
            chk("R5 compare on byte 64", hit_at0, 64);
            chk("R8 mismatching slot1 silent", hit_cnt1, 0);
            chk("R8 wake follows any slot", wake_cnt, 1);
        end

        // R6 R10: short frames compare on the last byte
        for (int len = 1; len <= 20; len++) begin
            for (int i = 0; i < 32; i++) fr[i] = 8'(i * 53 + len * 7 + 9);
            prog(0, '1, ref_crc('1, len));
            prog(1, '1, ref_crc('1, len + 1));
            clear_hits(); send_frame(len);
            chk("R6 R10 short frame single pulse", hit_cnt0, 1);
            chk("R6 compare after last byte", hit_at0, len);
            chk("R6 extra-byte slot silent", hit_cnt1, 0);
        end

        // R8: both slots hit together, wake still one pulse
        for (int i = 0; i < 16; i++) fr[i] = 8'(i + 100);
        prog(0, 64'h00F0, ref_crc(64'h00F0, 16));
        prog(1, 64'h0F0F, ref_crc(64'h0F0F, 16));
        clear_hits(); send_frame(16);
        chk("R8 slot0 hit", hit_cnt0, 1);
        chk("R8 slot1 hit", hit_cnt1, 1);
        chk("R8 wake single", wake_cnt, 1);

        // R9: restart mid-frame, then stray bytes outside a frame
        fr[0] = 8'hAA; fr[1] = 8'hBB; fr[2] = 8'hCC; fr[3] = 8'hDD;
        for (int i = 4; i < 8; i++) fr[i] = 8'(i);
        prog(0, 64'hF, ref_crc(64'hF, 4));
        prog(1, 64'h0, 32'h0);
        clear_hits();
        for (int i = 0; i < 6; i++) push(8'(8'h10 + i), i == 0, 1'b0);
        send_frame(8);
        chk("R9 restart match count", hit_cnt0, 1);
        chk("R9 restart match timing", hit_at0, 14);
        clear_hits();
        for (int i = 0; i < 8; i++) push(fr[i], 1'b0, i == 7);
        idle(3);
        chk("R9 stray bytes ignored", hit_cnt0, 0);
        clear_hits(); send_frame(8);
        chk("R9 next frame after stray", hit_cnt0, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule